// File: doc/BRIEF.md
# Cycle-Stealing Bitmap Memory Controller

This controller sits between a raster display refill path and a processor that edits a one-bit-per-pixel image. The image lives in a memory built from several cards. Each card holds a number of one-bit-wide chips that all see the same common address. Every time the display side raises a refill request, the controller runs one fixed slot. First it reads the display address with every chip enabled and captures the parallel word into the display latches. It then switches the address path to the processor's screen address and performs a read-modify-write on the single bit chosen by chip enable.

The processor sees a high address half (card and common address), a low address half (chip number), a write flag and a data bit. Each of these is loaded through one operation code. Three ways of arming a write are offered. Some codes load an address half and arm a write of a fixed 0 or 1 in the same step. A separate code arms a write with the bus data bit. The write flag also serves as a busy indication. It stays set until the read-modify-write that consumes it has finished. Electrical memory timing is reduced to a fixed number of clock cycles per read phase.

Top module: `scm_ctrl`

## Requirements
- R1: When a request is accepted, the display address is captured on that edge. Latch bit `c*CHIPS+k` then receives the stored bit of card c, chip k at that address. The latch changes only at the end of the all-chip read phase.
- R2: Processor operation codes are as follows. 0 loads the high half: card in the top CARD_W bits of the data, common address in the low COMMON_W bits. 1 loads the low half from data bits [CHIP_W-1:0]. 2 arms a write whose data is bus bit 0. 3 and 4 load the high half and arm a write of 0 and 1 respectively. 5 and 6 load the low half and arm a write of 0 and 1 respectively. 7 does nothing.
- R3: Every slot reads the bit at the transferred processor address. `rd_bit` then holds the value that bit had before the slot's write, whether or not a write was armed.
- R4: An armed slot stores the data bit into only the selected chip at the common address. All other stored bits keep their values.
- R5: Operation codes 2 to 6, accepted while not busy, set `busy` on the next edge.
- R6: `busy` clears on the edge that ends the write cycle of the slot that carried the armed write. In every other cycle it holds its value.
- R7: While `busy` is high, every processor operation is ignored. This covers both address halves, the data bit and the flag.
- R8: The address buffers are copied into the working address only at the end of the display read phase. A load that arrives later in the slot takes effect in the next slot.
- R9: A chip number of CHIPS or above enables no chip. The read then returns 0 and no stored bit changes.
- R10: A refill request that arrives while a slot is running is ignored.
- R11: After reset, `busy`, `rd_bit`, `disp_lat`, `mem_cs` and `mem_we` are all 0.
- R12: A slot lasts 2*RD_CYC+1 cycles. It has RD_CYC cycles with all chips enabled, then RD_CYC+1 cycles with at most one chip enabled. The write strobe can rise only in the last of those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_req | input | 1 | Display refill request |
| disp_addr | input | COMMON_W (12) | Display common address |
| cpu_we | input | 1 | Processor operation strobe |
| cpu_op | input | 3 | Processor operation code (R2) |
| cpu_wdata | input | CARD_W+COMMON_W (14) | Processor data |
| busy | output | 1 | Write flag / busy indication |
| rd_bit | output | 1 | Bit read in the last slot |
| disp_lat | output | 2**CARD_W*CHIPS (40) | Display latches |
| mem_addr | output | COMMON_W (12) | Shared common address to all chips |
| mem_cs | output | 2**CARD_W*CHIPS (40) | Per-chip enables |
| mem_we | output | 1 | Write strobe to all chips |
| mem_wdata | output | 1 | Write data to all chips |
| mem_rdata | input | 2**CARD_W*CHIPS (40) | Per-chip read data, 0 when not enabled |

## Verification
Within one slot, a processor register operation can coincide with the copy of the address buffers into the working address. A second refill request can also coincide with a slot that is still running. The bench injects a high-half load on the cycle right after the copy. It checks that `rd_bit` still returns the earlier address, and that the following slot returns the new one. It also arms a write at that same point and expects `busy` to survive the slot, with the bit changing only one slot later. A request raised during the all-chip phase must leave the latches holding the first address's column.

// File: rtl/scm_pkg.sv
`timescale 1ns/1ps
package scm_pkg;

    typedef enum logic [1:0] {
        SL_IDLE = 2'd0,
        SL_DISP = 2'd1,
        SL_PRD  = 2'd2,
        SL_PWR  = 2'd3
    } slot_e;

    typedef enum logic [2:0] {
        OP_HI    = 3'd0,
        OP_LO    = 3'd1,
        OP_ARM   = 3'd2,
        OP_HI_W0 = 3'd3,
        OP_HI_W1 = 3'd4,
        OP_LO_W0 = 3'd5,
        OP_LO_W1 = 3'd6,
        OP_NOP   = 3'd7
    } cpu_op_e;

    typedef struct packed {
        logic ld_hi;
        logic ld_lo;
        logic arm;
        logic use_bus;
        logic fixed;
    } op_dec_t;

    function automatic op_dec_t decode_op(input logic [2:0] op);
        op_dec_t d;
        d = '0;
        case (op)
            OP_HI:    d.ld_hi = 1'b1;
            OP_LO:    d.ld_lo = 1'b1;
            OP_ARM:   begin d.arm = 1'b1; d.use_bus = 1'b1; end
            OP_HI_W0: begin d.ld_hi = 1'b1; d.arm = 1'b1; end
            OP_HI_W1: begin d.ld_hi = 1'b1; d.arm = 1'b1; d.fixed = 1'b1; end
            OP_LO_W0: begin d.ld_lo = 1'b1; d.arm = 1'b1; end
            OP_LO_W1: begin d.ld_lo = 1'b1; d.arm = 1'b1; d.fixed = 1'b1; end
            default:  d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/scm_cpu_regs.sv
`timescale 1ns/1ps
module scm_cpu_regs
    import scm_pkg::*;
#(
    parameter int HI_W   = 14,
    parameter int CHIP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_we,
    input  logic [2:0]        cpu_op,
    input  logic [HI_W-1:0]   cpu_wdata,
    input  logic              wr_done,
    output logic [HI_W-1:0]   hi_buf,
    output logic [CHIP_W-1:0] lo_buf,
    output logic              flag,
    output logic              flag_d
);
    op_dec_t dec;
    logic    accept;

    always_comb begin
        dec    = decode_op(cpu_op);
        accept = cpu_we && !flag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_buf <= '0;
            lo_buf <= '0;
            flag   <= 1'b0;
            flag_d <= 1'b0;
        end else begin
            if (accept && dec.ld_hi) hi_buf <= cpu_wdata;
            if (accept && dec.ld_lo) lo_buf <= cpu_wdata[CHIP_W-1:0];
            if (accept && dec.arm) begin
                flag   <= 1'b1;
                flag_d <= dec.use_bus ? cpu_wdata[0] : dec.fixed;
            end else if (wr_done) begin
                flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/scm_slot_seq.sv
`timescale 1ns/1ps
module scm_slot_seq
    import scm_pkg::*;
#(
    parameter int RD_CYC = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  disp_req,
    output slot_e state,
    output logic  step
);
    localparam int CW = (RD_CYC > 1) ? $clog2(RD_CYC) : 1;

    logic [CW-1:0] cnt;

    always_comb step = (state == SL_DISP || state == SL_PRD) && (cnt == CW'(RD_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SL_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                SL_IDLE: if (disp_req) begin
                    state <= SL_DISP;
                    cnt   <= '0;
                end
                SL_DISP: if (step) begin
                    state <= SL_PRD;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                SL_PRD: if (step) state <= SL_PWR;
                        else      cnt   <= cnt + 1'b1;
                default: state <= SL_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/scm_chip_sel.sv
`timescale 1ns/1ps
module scm_chip_sel #(
    parameter int CARD_W = 2,
    parameter int CHIP_W = 4,
    parameter int CHIPS  = 10
) (
    input  logic                          all_en,
    input  logic                          one_en,
    input  logic [CARD_W-1:0]             card,
    input  logic [CHIP_W-1:0]             chip,
    output logic [(2**CARD_W)*CHIPS-1:0]  cs
);
    for (genvar c = 0; c < 2**CARD_W; c++) begin : g_card
        for (genvar k = 0; k < CHIPS; k++) begin : g_chip
            assign cs[c*CHIPS+k] = all_en |
                (one_en && card == CARD_W'(c) && chip == CHIP_W'(k));
        end
    end
endmodule

// File: rtl/scm_ctrl.sv
`timescale 1ns/1ps
module scm_ctrl
    import scm_pkg::*;
#(
    parameter int CARD_W   = 2,
    parameter int COMMON_W = 12,
    parameter int CHIP_W   = 4,
    parameter int CHIPS    = 10,
    parameter int RD_CYC   = 2
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               disp_req,
    input  logic [COMMON_W-1:0]                disp_addr,
    input  logic                               cpu_we,
    input  logic [2:0]                         cpu_op,
    input  logic [CARD_W+COMMON_W-1:0]         cpu_wdata,
    output logic                               busy,
    output logic                               rd_bit,
    output logic [(2**CARD_W)*CHIPS-1:0]       disp_lat,
    output logic [COMMON_W-1:0]                mem_addr,
    output logic [(2**CARD_W)*CHIPS-1:0]       mem_cs,
    output logic                               mem_we,
    output logic                               mem_wdata,
    input  logic [(2**CARD_W)*CHIPS-1:0]       mem_rdata
);
    localparam int HI_W = CARD_W + COMMON_W;
    localparam int NCS  = (2**CARD_W) * CHIPS;

    slot_e               state;
    logic                step;
    logic [HI_W-1:0]     hi_buf;
    logic [CHIP_W-1:0]   lo_buf;
    logic                flag, flag_d;
    logic [COMMON_W-1:0] dptr, wk_common;
    logic [CARD_W-1:0]   wk_card;
    logic [CHIP_W-1:0]   wk_chip;
    logic                wk_arm, wk_d;
    logic                wr_done, all_en, one_en;

    scm_slot_seq #(.RD_CYC(RD_CYC)) u_seq (
        .clk(clk), .rst(rst), .disp_req(disp_req), .state(state), .step(step)
    );

    scm_cpu_regs #(.HI_W(HI_W), .CHIP_W(CHIP_W)) u_regs (
        .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_op(cpu_op),
        .cpu_wdata(cpu_wdata), .wr_done(wr_done),
        .hi_buf(hi_buf), .lo_buf(lo_buf), .flag(flag), .flag_d(flag_d)
    );

    scm_chip_sel #(.CARD_W(CARD_W), .CHIP_W(CHIP_W), .CHIPS(CHIPS)) u_sel (
        .all_en(all_en), .one_en(one_en), .card(wk_card), .chip(wk_chip), .cs(mem_cs)
    );

    always_comb begin
        all_en    = (state == SL_DISP);
        one_en    = (state == SL_PRD) || (state == SL_PWR);
        wr_done   = (state == SL_PWR) && wk_arm;
        mem_we    = wr_done;
        mem_wdata = wk_d;
        mem_addr  = all_en ? dptr : wk_common;
        busy      = flag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dptr      <= '0;
            wk_common <= '0;
            wk_card   <= '0;
            wk_chip   <= '0;
            wk_arm    <= 1'b0;
            wk_d      <= 1'b0;
            disp_lat  <= '0;
            rd_bit    <= 1'b0;
        end else begin
            if (state == SL_IDLE && disp_req) dptr <= disp_addr;
            if (state == SL_DISP && step) begin
                disp_lat             <= mem_rdata;
                {wk_card, wk_common} <= hi_buf;
                wk_chip              <= lo_buf;
                wk_arm               <= flag;
                wk_d                 <= flag_d;
            end
            if (state == SL_PRD && step) rd_bit <= |mem_rdata;
        end
    end
endmodule

// File: rtl/scm_checker.sv
`timescale 1ns/1ps
module scm_checker #(
    parameter int NCS = 40
) (
    input logic           clk,
    input logic           rst,
    input logic           busy,
    input logic           cpu_we,
    input logic [2:0]     cpu_op,
    input logic           mem_we,
    input logic [NCS-1:0] mem_cs,
    input logic [NCS-1:0] disp_lat
);
    p_single_chip_write_r4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $onehot0(mem_cs));

    p_write_needs_flag_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    p_flag_clears_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !busy);

    p_busy_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_we) |=> busy);

    p_arm_sets_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && cpu_we && cpu_op >= 3'd2 && cpu_op <= 3'd6) |=> busy);

    p_bulk_read_only_r12: assert property (@(posedge clk) disable iff (rst)
        ($countones(mem_cs) > 1) |-> !mem_we);

    p_latch_after_bulk_r1: assert property (@(posedge clk) disable iff (rst)
        !$stable(disp_lat) |-> $past(&mem_cs));
endmodule

bind scm_ctrl scm_checker #(.NCS(NCS)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .cpu_we(cpu_we), .cpu_op(cpu_op),
    .mem_we(mem_we), .mem_cs(mem_cs), .disp_lat(disp_lat)
);

// File: tb/test_scm_ctrl.sv
`timescale 1ns/1ps
module test_scm_ctrl;
    localparam int CW   = 1;
    localparam int AW   = 3;
    localparam int XW   = 2;
    localparam int CH   = 3;
    localparam int RC   = 2;
    localparam int NCS  = (2**CW) * CH;
    localparam int HW   = CW + AW;
    localparam int NA   = 2**AW;
    localparam int SLOT = 2*RC + 1;

    logic           clk = 1'b0;
    logic           rst;
    logic           disp_req;
    logic [AW-1:0]  disp_addr;
    logic           cpu_we;
    logic [2:0]     cpu_op;
    logic [HW-1:0]  cpu_wdata;
    logic           busy, rd_bit;
    logic [NCS-1:0] disp_lat;
    logic [AW-1:0]  mem_addr;
    logic [NCS-1:0] mem_cs;
    logic           mem_we, mem_wdata;
    logic [NCS-1:0] mem_rdata;

    logic [NA-1:0]  mem   [NCS];
    logic [NA-1:0]  ref_m [NCS];

    int n_vec = 0;
    int n_bad = 0;
    int inj_at = -1;
    logic inj_req;
    logic [2:0] inj_op;
    logic [HW-1:0] inj_data;
    int mon_all, mon_one, mon_multi, mon_we;

    always #4 clk = ~clk;

    scm_ctrl #(.CARD_W(CW), .COMMON_W(AW), .CHIP_W(XW), .CHIPS(CH), .RD_CYC(RC)) i_scm_ctrl (
        .clk(clk), .rst(rst), .disp_req(disp_req), .disp_addr(disp_addr),
        .cpu_we(cpu_we), .cpu_op(cpu_op), .cpu_wdata(cpu_wdata),
        .busy(busy), .rd_bit(rd_bit), .disp_lat(disp_lat),
        .mem_addr(mem_addr), .mem_cs(mem_cs), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always_comb
        for (int i = 0; i < NCS; i++) mem_rdata[i] = mem_cs[i] & mem[i][mem_addr];

    always @(posedge clk)
        if (mem_we)
            for (int i = 0; i < NCS; i++)
                if (mem_cs[i]) mem[i][mem_addr] <= mem_wdata;

    function automatic logic pat(input int i, input int a, input int s);
        return logic'(((i*5 + a*3 + s*7) / 2) % 2);
    endfunction

    function automatic logic [NCS-1:0] exp_lat(input int a);
        logic [NCS-1:0] v;
        for (int i = 0; i < NCS; i++) v[i] = ref_m[i][a];
        return v;
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic cpu(input logic [2:0] op, input logic [HW-1:0] d);
        cpu_we = 1'b1; cpu_op = op; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic slot(input int a);
        disp_req = 1'b1; disp_addr = AW'(a);
        @(negedge clk);
        disp_req = 1'b0;
        mon_all = 0; mon_one = 0; mon_multi = 0; mon_we = 0;
        for (int j = 0; j < SLOT; j++) begin
            if (&mem_cs) mon_all++;
            else if (|mem_cs) mon_one++;
            if (!(&mem_cs) && $countones(mem_cs) > 1) mon_multi++;
            if (mem_we) mon_we++;
            if (j == inj_at) begin
                if (inj_req) begin disp_req = 1'b1; disp_addr = inj_data[AW-1:0]; end
                else begin cpu_we = 1'b1; cpu_op = inj_op; cpu_wdata = inj_data; end
            end
            @(negedge clk);
            disp_req = 1'b0; cpu_we = 1'b0;
        end
        inj_at = -1;
    endtask

    function automatic logic [HW-1:0] hi_of(input int c, input int a);
        return HW'(c * NA + a);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst = 1'b1; disp_req = 1'b0; disp_addr = '0;
        cpu_we = 1'b0; cpu_op = '0; cpu_wdata = '0;
        for (int i = 0; i < NCS; i++)
            for (int a = 0; a < NA; a++) begin
                mem[i][a] = pat(i, a, 0);
                ref_m[i][a] = pat(i, a, 0);
            end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 busy", busy, 0);
        chk("R11 rd_bit", rd_bit, 0);
        chk("R11 disp_lat", disp_lat, 0);
        chk("R11 mem_cs", mem_cs, 0);
        chk("R11 mem_we", mem_we, 0);

        // R2 R3 R4 R5 R6 R9: every card, common address and chip number, written and read back
        for (int c = 0; c < 2**CW; c++)
            for (int a = 0; a < NA; a++)
                for (int k = 0; k < 2**XW; k++) begin
                    logic v, old;
                    v = pat(c*CH + k, a, 1);
                    case (a % 3)
                        0: begin cpu(3'd0, hi_of(c, a)); cpu(v ? 3'd6 : 3'd5, HW'(k)); end
                        1: begin cpu(3'd1, HW'(k)); cpu(v ? 3'd4 : 3'd3, hi_of(c, a)); end
                        default: begin cpu(3'd0, hi_of(c, a)); cpu(3'd1, HW'(k));
                                       cpu(3'd2, HW'(v)); end
                    endcase
                    chk("R5 busy after arm", busy, 1);
                    old = (k < CH) ? ref_m[c*CH + k][a] : 1'b0;
                    slot((a + 3) % NA);
                    chk("R3 old bit read", rd_bit, old);
                    chk("R6 busy cleared", busy, 0);
                    chk("R4 one write strobe", mon_we, 1);
                    if (k < CH) ref_m[c*CH + k][a] = v;
                end

        // R1 display column reads
        for (int a = 0; a < NA; a++) begin
            slot(a);
            chk("R1 latch column", disp_lat, exp_lat(a));
        end

        // R3 R12 read-only slots and slot shape
        for (int i = 0; i < NCS; i++) begin
            cpu(3'd0, hi_of(i / CH, (i * 3) % NA));
            cpu(3'd1, HW'(i % CH));
            slot(0);
            chk("R3 plain read", rd_bit, ref_m[i][(i * 3) % NA]);
            chk("R12 all-chip cycles", mon_all, RC);
            chk("R12 single-chip cycles", mon_one, RC + 1);
            chk("R12 no partial multi", mon_multi, 0);
            chk("R12 no strobe unarmed", mon_we, 0);
        end

        // R8 load after transfer lands in next slot; A=(0,1,0) B=(1,6,0)
        cpu(3'd0, hi_of(0, 1)); cpu(3'd6, HW'(0)); slot(0); ref_m[0][1] = 1'b1;
        cpu(3'd0, hi_of(1, 6)); cpu(3'd5, HW'(0)); slot(0); ref_m[CH][6] = 1'b0;
        cpu(3'd0, hi_of(0, 1));
        inj_at = 2; inj_req = 1'b0; inj_op = 3'd0; inj_data = hi_of(1, 6);
        slot(0);
        chk("R8 old address used", rd_bit, 1);
        slot(0);
        chk("R8 new address next slot", rd_bit, 0);

        // R8 R6 arm after transfer is held over one slot
        cpu(3'd0, hi_of(0, 1));
        inj_at = 2; inj_req = 1'b0; inj_op = 3'd2; inj_data = HW'(0);
        slot(0);
        chk("R6 busy kept for late arm", busy, 1);
        chk("R8 no write yet", rd_bit, 1);
        slot(0);
        chk("R6 busy cleared next slot", busy, 0);
        chk("R3 old value before write", rd_bit, 1);
        ref_m[0][1] = 1'b0;
        slot(0);
        chk("R4 late write landed", rd_bit, 0);

        // R7 operations while busy are ignored
        cpu(3'd2, HW'(1));
        cpu(3'd0, hi_of(1, 6));
        cpu(3'd2, HW'(0));
        cpu(3'd7, HW'(0));
        chk("R7 still busy", busy, 1);
        slot(0);
        chk("R7 address kept", rd_bit, 0);
        ref_m[0][1] = 1'b1;
        slot(0);
        chk("R7 data kept", rd_bit, 1);

        // R10 request during slot ignored
        begin
            int q;
            q = 1;
            for (int a = 1; a < NA; a++) if (exp_lat(a) != exp_lat(0)) q = a;
            inj_at = 1; inj_req = 1'b1; inj_data = HW'(q);
            slot(0);
            chk("R10 latch from first request", disp_lat, exp_lat(0));
            chk("R10 back to idle", mem_cs, 0);
        end

        // R4 R9 whole array matches expected contents
        begin
            int miss;
            miss = 0;
            for (int i = 0; i < NCS; i++)
                for (int a = 0; a < NA; a++)
                    if (mem[i][a] !== ref_m[i][a]) miss++;
            chk("R4 R9 stored array", miss, 0);
        end

        summary();
    end
endmodule